// File: doc/BRIEF.md
# Clock Frequency Source Selector

This block decides which frequency configuration a clock synthesizer runs with. At power-up it captures the frequency-select, drive-strength and output-select strap pins while the active-low power-good input is low, and holds them once power-good goes high. After that, the effective 5-bit table index comes from one of three places: the latched straps, a software index, or a watchdog fallback. A separate mode flag hands frequency control to direct M/N divider programming instead of the table.

A watchdog timeout pulse drops M/N mode and forces a fallback index. That index is either the latched straps or a programmed safe index. It stays in force until software rewrites the index configuration. The block also does these jobs:
- decodes the CPU/66 MHz/PCI ratio code into divisor values;
- flags which spread type the chosen index uses;
- keeps the two output-select bits, which start from the straps and can then be written;
- returns the latched straps for readback.

Every output comes from one register stage, so a change of configuration appears on all outputs in the same cycle.

Top module: `fsrc_select`

## Requirements
- R1: After reset the outputs are: index 31, spread off, down-spread flag 1, M/N mode 0, M and N 0, ratio code 2 with divisors 3/6/12, sel_2448 0, sel_4866 1, fs_rb 31, msel_rb 3.
- R2: On every clock edge where pwrgd_n is 0, the FS, drive-select and output-select strap pins are captured. On edges where pwrgd_n is 1, the captured strap values are held.
- R3: Unless a fallback is in force, the index output equals sw_idx when sw_idx_en is 1, and the latched FS straps when sw_idx_en is 0.
- R4: spread_on follows spread_en. spread_down is 1 exactly when the index output is 28 or higher, which selects down spread; otherwise center spread is used.
- R5: mn_mode is set or cleared by an mn_wr pulse carrying mn_wdata, and holds otherwise. m_out (5 bits) and n_out (9 bits) present m_in and n_in.
- R6: Ratio codes map to CPU/66/PCI divisors as 0→2/5/10, 1→2/6/12, 2→3/6/12, 3→4/6/12, 4→4/8/16, 5→6/6/12. Codes 6 to 15 give 3/6/12.
- R7: A wdt_timeout pulse clears mn_mode and forces the index. The forced index is safe_idx when safe_sel is 1, and the latched FS straps when safe_sel is 0. A timeout wins over an mn_wr or idx_wr in the same cycle.
- R8: A forced index stays in force, whatever sw_idx_en and sw_idx do, until an idx_wr pulse without a timeout releases it.
- R9: While pwrgd_n is 0, sel_2448 and sel_4866 follow their strap pins and sel_wr is ignored. While pwrgd_n is 1, sel_wr loads sel_2448_wdata and sel_4866_wdata; without a write, both bits hold.
- R10: fs_rb presents the latched FS straps. msel_rb presents the latched drive-select straps.
- R11: Every output reflects the inputs of the previous clock edge. A single event, such as a timeout, changes all affected outputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwrgd_n | input | 1 | Active-low power-good; straps are captured while it is low |
| strap_fs | input | 5 | Frequency-select strap pins |
| strap_msel | input | 2 | Drive-strength strap pins |
| strap_s2448 | input | 1 | 24/48 MHz select strap |
| strap_s4866 | input | 1 | 48/66 MHz select strap |
| sw_idx_en | input | 1 | 1 = software index, 0 = strap index |
| sw_idx | input | 5 | Software table index |
| spread_en | input | 1 | Spread spectrum enable |
| safe_sel | input | 1 | Fallback source: 1 = safe_idx, 0 = straps |
| safe_idx | input | 5 | Safe fallback index |
| idx_wr | input | 1 | Index configuration written; releases a fallback |
| mn_wr | input | 1 | M/N mode write strobe |
| mn_wdata | input | 1 | M/N mode write value |
| m_in | input | 5 | M divider field |
| n_in | input | 9 | N divider field |
| ratio_in | input | 4 | Ratio select code |
| sel_wr | input | 1 | Output-select write strobe |
| sel_2448_wdata | input | 1 | Write value for sel_2448 |
| sel_4866_wdata | input | 1 | Write value for sel_4866 |
| wdt_timeout | input | 1 | Watchdog timeout pulse |
| idx_out | output | 5 | Effective table index |
| spread_on | output | 1 | Spread enabled |
| spread_down | output | 1 | 1 = down spread, 0 = center spread |
| mn_mode | output | 1 | M/N programming mode active |
| m_out | output | 5 | M divider |
| n_out | output | 9 | N divider |
| ratio_out | output | 4 | Ratio code |
| cpu_div | output | 5 | CPU divisor |
| v66_div | output | 5 | 66 MHz divisor |
| pci_div | output | 5 | PCI divisor |
| sel_2448 | output | 1 | 0 = 24 MHz, 1 = 48 MHz |
| sel_4866 | output | 1 | 0 = 48 MHz, 1 = 66 MHz |
| fs_rb | output | 5 | Latched FS straps |
| msel_rb | output | 2 | Latched drive-select straps |

## Verification
The bench targets the following cases:
- **Timeout with a write in the same cycle.** A design that lets mn_wr or idx_wr win would leave M/N mode on, or drop the fallback at once.
- **A fallback that must outlast changes to sw_idx_en.** A design that rechecks the software enable would lose the safe index.
- **Writes to the output-select bits while power-good is low.** A design that accepts them would override the straps.
- **A power-good glitch late in the run.** It must re-capture the straps and change the strap readback. A design with a one-shot latch would miss the new straps.
- **Ratio codes above 5 and indices 27 to 28.** These catch a wrong default divisor and an off-by-one in the down-spread boundary.

// File: rtl/fsrc_pkg.sv
package fsrc_pkg;
    localparam int FS_W      = 5;
    localparam int MSEL_W    = 2;
    localparam int M_W       = 5;
    localparam int N_W       = 9;
    localparam int RATIO_W   = 4;
    localparam int DIV_W     = 5;
    localparam int DOWN_FROM = 28;

    typedef struct packed {
        logic [DIV_W-1:0] cpu;
        logic [DIV_W-1:0] v66;
        logic [DIV_W-1:0] pci;
    } div_set_t;

    function automatic div_set_t mk_div(input int c, input int v, input int p);
        div_set_t r;
        r.cpu = DIV_W'(c);
        r.v66 = DIV_W'(v);
        r.pci = DIV_W'(p);
        return r;
    endfunction
endpackage

// File: rtl/fsrc_strap_latch.sv
module fsrc_strap_latch #(
    parameter int FS_W   = fsrc_pkg::FS_W,
    parameter int MSEL_W = fsrc_pkg::MSEL_W
) (
    input  logic              capture,
    input  logic [FS_W-1:0]   pin_fs,
    input  logic [MSEL_W-1:0] pin_msel,
    input  logic [FS_W-1:0]   held_fs,
    input  logic [MSEL_W-1:0] held_msel,
    output logic [FS_W-1:0]   next_fs,
    output logic [MSEL_W-1:0] next_msel
);
    // Transparent while power-good is low, holding otherwise.
    always_comb begin
        if (capture) begin
            next_fs   = pin_fs;
            next_msel = pin_msel;
        end else begin
            next_fs   = held_fs;
            next_msel = held_msel;
        end
    end
endmodule

// File: rtl/fsrc_ratio_dec.sv
module fsrc_ratio_dec #(
    parameter int RATIO_W = fsrc_pkg::RATIO_W
) (
    input  logic [RATIO_W-1:0] code,
    output fsrc_pkg::div_set_t divs
);
    import fsrc_pkg::*;
    always_comb begin
        case (code)
            RATIO_W'(0): divs = mk_div(2, 5, 10);
            RATIO_W'(1): divs = mk_div(2, 6, 12);
            RATIO_W'(3): divs = mk_div(4, 6, 12);
            RATIO_W'(4): divs = mk_div(4, 8, 16);
            RATIO_W'(5): divs = mk_div(6, 6, 12);
            default:     divs = mk_div(3, 6, 12);
        endcase
    end
endmodule

// File: rtl/fsrc_select.sv
module fsrc_select #(
    parameter int FS_W      = fsrc_pkg::FS_W,
    parameter int MSEL_W    = fsrc_pkg::MSEL_W,
    parameter int M_W       = fsrc_pkg::M_W,
    parameter int N_W       = fsrc_pkg::N_W,
    parameter int RATIO_W   = fsrc_pkg::RATIO_W,
    parameter int DIV_W     = fsrc_pkg::DIV_W,
    parameter int DOWN_FROM = fsrc_pkg::DOWN_FROM
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwrgd_n,
    input  logic [FS_W-1:0]    strap_fs,
    input  logic [MSEL_W-1:0]  strap_msel,
    input  logic               strap_s2448,
    input  logic               strap_s4866,
    input  logic               sw_idx_en,
    input  logic [FS_W-1:0]    sw_idx,
    input  logic               spread_en,
    input  logic               safe_sel,
    input  logic [FS_W-1:0]    safe_idx,
    input  logic               idx_wr,
    input  logic               mn_wr,
    input  logic               mn_wdata,
    input  logic [M_W-1:0]     m_in,
    input  logic [N_W-1:0]     n_in,
    input  logic [RATIO_W-1:0] ratio_in,
    input  logic               sel_wr,
    input  logic               sel_2448_wdata,
    input  logic               sel_4866_wdata,
    input  logic               wdt_timeout,
    output logic [FS_W-1:0]    idx_out,
    output logic               spread_on,
    output logic               spread_down,
    output logic               mn_mode,
    output logic [M_W-1:0]     m_out,
    output logic [N_W-1:0]     n_out,
    output logic [RATIO_W-1:0] ratio_out,
    output logic [DIV_W-1:0]   cpu_div,
    output logic [DIV_W-1:0]   v66_div,
    output logic [DIV_W-1:0]   pci_div,
    output logic               sel_2448,
    output logic               sel_4866,
    output logic [FS_W-1:0]    fs_rb,
    output logic [MSEL_W-1:0]  msel_rb
);
    localparam logic [FS_W-1:0]   FS_PULL   = '1;
    localparam logic [MSEL_W-1:0] MSEL_PULL = '1;
    localparam logic [FS_W-1:0]   DOWN_IDX  = FS_W'(DOWN_FROM);

    typedef struct packed {
        logic [FS_W-1:0]    fs;
        logic [MSEL_W-1:0]  msel;
        logic               s2448;
        logic               s4866;
        logic               mn_en;
        logic               forced;
        logic [FS_W-1:0]    forced_idx;
        logic [FS_W-1:0]    idx;
        logic               spread_on;
        logic               spread_down;
        logic [M_W-1:0]     m;
        logic [N_W-1:0]     n;
        logic [RATIO_W-1:0] ratio;
        logic [DIV_W-1:0]   cpu;
        logic [DIV_W-1:0]   v66;
        logic [DIV_W-1:0]   pci;
    } state_t;

    localparam state_t RESET_ST = '{
        fs: FS_PULL, msel: MSEL_PULL, s2448: 1'b0, s4866: 1'b1,
        mn_en: 1'b0, forced: 1'b0, forced_idx: '0, idx: FS_PULL,
        spread_on: 1'b0, spread_down: (FS_PULL >= DOWN_IDX),
        m: '0, n: '0, ratio: RATIO_W'(2),
        cpu: DIV_W'(3), v66: DIV_W'(6), pci: DIV_W'(12)
    };

    state_t st_d, st_q;
    logic [FS_W-1:0]    fs_nx;
    logic [MSEL_W-1:0]  msel_nx;
    fsrc_pkg::div_set_t divs;

    fsrc_strap_latch #(.FS_W(FS_W), .MSEL_W(MSEL_W)) u_latch (
        .capture   (!pwrgd_n),
        .pin_fs    (strap_fs),
        .pin_msel  (strap_msel),
        .held_fs   (st_q.fs),
        .held_msel (st_q.msel),
        .next_fs   (fs_nx),
        .next_msel (msel_nx)
    );

    fsrc_ratio_dec #(.RATIO_W(RATIO_W)) u_ratio (
        .code (ratio_in),
        .divs (divs)
    );

    always_comb begin
        st_d      = st_q;
        st_d.fs   = fs_nx;
        st_d.msel = msel_nx;

        if (!pwrgd_n) begin
            st_d.s2448 = strap_s2448;
            st_d.s4866 = strap_s4866;
        end else if (sel_wr) begin
            st_d.s2448 = sel_2448_wdata;
            st_d.s4866 = sel_4866_wdata;
        end

        if (wdt_timeout) begin
            st_d.mn_en      = 1'b0;
            st_d.forced     = 1'b1;
            st_d.forced_idx = safe_sel ? safe_idx : fs_nx;
        end else begin
            if (mn_wr)  st_d.mn_en  = mn_wdata;
            if (idx_wr) st_d.forced = 1'b0;
        end

        if (st_d.forced)   st_d.idx = st_d.forced_idx;
        else if (sw_idx_en) st_d.idx = sw_idx;
        else               st_d.idx = fs_nx;

        st_d.spread_on   = spread_en;
        st_d.spread_down = (st_d.idx >= DOWN_IDX);
        st_d.m           = m_in;
        st_d.n           = n_in;
        st_d.ratio       = ratio_in;
        st_d.cpu         = divs.cpu;
        st_d.v66         = divs.v66;
        st_d.pci         = divs.pci;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    assign idx_out     = st_q.idx;
    assign spread_on   = st_q.spread_on;
    assign spread_down = st_q.spread_down;
    assign mn_mode     = st_q.mn_en;
    assign m_out       = st_q.m;
    assign n_out       = st_q.n;
    assign ratio_out   = st_q.ratio;
    assign cpu_div     = st_q.cpu;
    assign v66_div     = st_q.v66;
    assign pci_div     = st_q.pci;
    assign sel_2448    = st_q.s2448;
    assign sel_4866    = st_q.s4866;
    assign fs_rb       = st_q.fs;
    assign msel_rb     = st_q.msel;
endmodule

// File: rtl/fsrc_select_chk.sv
module fsrc_select_chk #(
    parameter int FS_W      = fsrc_pkg::FS_W,
    parameter int MSEL_W    = fsrc_pkg::MSEL_W,
    parameter int M_W       = fsrc_pkg::M_W,
    parameter int N_W       = fsrc_pkg::N_W,
    parameter int RATIO_W   = fsrc_pkg::RATIO_W,
    parameter int DIV_W     = fsrc_pkg::DIV_W,
    parameter int DOWN_FROM = fsrc_pkg::DOWN_FROM
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pwrgd_n,
    input logic [FS_W-1:0]    strap_fs,
    input logic               strap_s2448,
    input logic               safe_sel,
    input logic [FS_W-1:0]    safe_idx,
    input logic               wdt_timeout,
    input logic [FS_W-1:0]    idx_out,
    input logic               spread_down,
    input logic               mn_mode,
    input logic [DIV_W-1:0]   cpu_div,
    input logic               sel_2448,
    input logic [FS_W-1:0]    fs_rb
);
    a_r7_timeout_clears_mn: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_timeout |=> !mn_mode);

    a_r7_safe_index: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_timeout && safe_sel) |=> (idx_out == $past(safe_idx)));

    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !pwrgd_n |=> (fs_rb == $past(strap_fs)));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pwrgd_n |=> (pwrgd_n -> $stable(fs_rb)));

    a_r9_strap_sel: assert property (@(posedge clk) disable iff (!rst_n)
        !pwrgd_n |=> (sel_2448 == $past(strap_s2448)));

    a_r4_down_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        spread_down == (idx_out >= FS_W'(DOWN_FROM)));

    a_r6_cpu_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_div inside {DIV_W'(2), DIV_W'(3), DIV_W'(4), DIV_W'(6)});
endmodule

bind fsrc_select fsrc_select_chk #(
    .FS_W(FS_W), .MSEL_W(MSEL_W), .M_W(M_W), .N_W(N_W),
    .RATIO_W(RATIO_W), .DIV_W(DIV_W), .DOWN_FROM(DOWN_FROM)
) u_chk (.*);

// File: tb/fsrc_select_bench.sv
module fsrc_select_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwrgd_n = 1'b0;
    logic [4:0] strap_fs = '0;
    logic [1:0] strap_msel = '0;
    logic strap_s2448 = 1'b0, strap_s4866 = 1'b0;
    logic sw_idx_en = 1'b0;
    logic [4:0] sw_idx = '0;
    logic spread_en = 1'b0, safe_sel = 1'b0;
    logic [4:0] safe_idx = '0;
    logic idx_wr = 1'b0, mn_wr = 1'b0, mn_wdata = 1'b0;
    logic [4:0] m_in = '0;
    logic [8:0] n_in = '0;
    logic [3:0] ratio_in = '0;
    logic sel_wr = 1'b0, sel_2448_wdata = 1'b0, sel_4866_wdata = 1'b0;
    logic wdt_timeout = 1'b0;
    logic [4:0] idx_out, m_out, cpu_div, v66_div, pci_div, fs_rb;
    logic spread_on, spread_down, mn_mode, sel_2448, sel_4866;
    logic [8:0] n_out;
    logic [3:0] ratio_out;
    logic [1:0] msel_rb;

    fsrc_select u_fsrc_select (.*);

    always #5 clk = ~clk;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // reference state
    logic [4:0] e_fs = 5'd31, e_fidx = '0, e_idx = 5'd31;
    logic [1:0] e_msel = 2'd3;
    logic e_s2448 = 1'b0, e_s4866 = 1'b1, e_mn = 1'b0, e_forced = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_div(input logic [3:0] c, input int which);
        int d[3];
        case (c)
            4'd0: d = '{2, 5, 10};
            4'd1: d = '{2, 6, 12};
            4'd3: d = '{4, 6, 12};
            4'd4: d = '{4, 8, 16};
            4'd5: d = '{6, 6, 12};
            default: d = '{3, 6, 12};
        endcase
        return d[which];
    endfunction

    // reference update from the inputs present at the coming edge
    task automatic model;
        if (!pwrgd_n) begin
            e_fs = strap_fs; e_msel = strap_msel;
            e_s2448 = strap_s2448; e_s4866 = strap_s4866;
        end else if (sel_wr) begin
            e_s2448 = sel_2448_wdata; e_s4866 = sel_4866_wdata;
        end
        if (wdt_timeout) begin
            e_mn = 1'b0; e_forced = 1'b1;
            e_fidx = safe_sel ? safe_idx : e_fs;
        end else begin
            if (mn_wr) e_mn = mn_wdata;
            if (idx_wr) e_forced = 1'b0;
        end
        e_idx = e_forced ? e_fidx : (sw_idx_en ? sw_idx : e_fs);
    endtask

    task automatic compare_all;
        chk("R3/R8", "idx_out", idx_out, e_idx);
        chk("R4", "spread_on", spread_on, spread_en);
        chk("R4", "spread_down", spread_down, int'(e_idx >= 5'd28));
        chk("R5/R7", "mn_mode", mn_mode, e_mn);
        chk("R5", "m_out", m_out, m_in);
        chk("R5", "n_out", n_out, n_in);
        chk("R6", "ratio_out", ratio_out, ratio_in);
        chk("R6", "cpu_div", cpu_div, exp_div(ratio_in, 0));
        chk("R6", "v66_div", v66_div, exp_div(ratio_in, 1));
        chk("R6", "pci_div", pci_div, exp_div(ratio_in, 2));
        chk("R9", "sel_2448", sel_2448, e_s2448);
        chk("R9", "sel_4866", sel_4866, e_s4866);
        chk("R10", "fs_rb", fs_rb, e_fs);
        chk("R10", "msel_rb", msel_rb, e_msel);
    endtask

    // inputs already set at the negedge; take one edge and check
    task automatic step;
        model();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        idx_wr = 1'b0; mn_wr = 1'b0; sel_wr = 1'b0; wdt_timeout = 1'b0;
    endtask

    task automatic rand_inputs(input bit allow_low);
        sw_idx_en = 1'($urandom);
        sw_idx = 5'($urandom);
        spread_en = 1'($urandom);
        safe_sel = 1'($urandom);
        safe_idx = 5'($urandom);
        m_in = 5'($urandom);
        n_in = 9'($urandom);
        ratio_in = 4'($urandom);
        strap_fs = 5'($urandom);
        strap_msel = 2'($urandom);
        strap_s2448 = 1'($urandom);
        strap_s4866 = 1'($urandom);
        idx_wr = ($urandom % 16) == 0;
        mn_wr = ($urandom % 5) == 0;
        mn_wdata = 1'($urandom);
        sel_wr = ($urandom % 5) == 0;
        sel_2448_wdata = 1'($urandom);
        sel_4866_wdata = 1'($urandom);
        wdt_timeout = ($urandom % 20) == 0;
        pwrgd_n = allow_low ? (($urandom % 25) != 0) : 1'b1;
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", "idx reset", idx_out, 31);
        chk("R1", "spread_down reset", spread_down, 1);
        chk("R1", "mn reset", mn_mode, 0);
        chk("R1", "ratio reset", ratio_out, 2);
        chk("R1", "cpu_div reset", cpu_div, 3);
        chk("R1", "sel_2448 reset", sel_2448, 0);
        chk("R1", "sel_4866 reset", sel_4866, 1);
        chk("R1", "fs_rb reset", fs_rb, 31);
        chk("R1", "msel_rb reset", msel_rb, 3);
        rst_n = 1'b1;

        // R2/R9: capture while power-good low, write ignored
        pwrgd_n = 1'b0; strap_fs = 5'd9; strap_msel = 2'd1;
        strap_s2448 = 1'b1; strap_s4866 = 1'b0;
        sel_wr = 1'b1; sel_2448_wdata = 1'b0; sel_4866_wdata = 1'b1;
        step();
        chk("R2", "captured fs", fs_rb, 9);
        chk("R9", "write ignored while low", sel_2448, 1);
        // R2: hold after release
        pwrgd_n = 1'b1; strap_fs = 5'd2; strap_msel = 2'd2;
        step();
        chk("R2", "held fs", fs_rb, 9);
        chk("R3", "strap index", idx_out, 9);

        // R4: boundary 27/28
        sw_idx_en = 1'b1; sw_idx = 5'd27; step();
        chk("R4", "idx 27 center", spread_down, 0);
        sw_idx = 5'd28; step();
        chk("R4", "idx 28 down", spread_down, 1);

        // R6: undefined ratio code
        ratio_in = 4'd11; step();
        chk("R6", "code 11 cpu", cpu_div, 3);

        // R7/R11: timeout beats same-cycle writes, all outputs move together
        mn_wr = 1'b1; mn_wdata = 1'b1; step();
        chk("R5", "mn set", mn_mode, 1);
        safe_sel = 1'b1; safe_idx = 5'd30;
        wdt_timeout = 1'b1; mn_wr = 1'b1; mn_wdata = 1'b1; idx_wr = 1'b1;
        step();
        chk("R11", "mn dropped with index", mn_mode, 0);
        chk("R11", "index changed same cycle", idx_out, 30);
        chk("R7", "down flag with safe idx", spread_down, 1);
        // R8: fallback persists until idx_wr
        sw_idx_en = 1'b0; step();
        sw_idx_en = 1'b1; sw_idx = 5'd3; step();
        chk("R8", "fallback held", idx_out, 30);
        idx_wr = 1'b1; step();
        chk("R8", "fallback released", idx_out, 3);
        // R7: strap-sourced fallback
        safe_sel = 1'b0; wdt_timeout = 1'b1; step();
        chk("R7", "strap fallback", idx_out, 9);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            rand_inputs(i > 50);
            step();
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule